// File: doc/BRIEF.md
# Flash Device Identification Probe

This block works out which parallel flash device is fitted by reading its two-byte identifier over a plain byte-wide bus. The bus has an address, write data, read data, a write strobe and a read strobe. A one-cycle start pulse launches a probe. The block first asks an external write gate to open and waits until the gate reports open. It then writes the identify command and waits a fixed number of microseconds, timed from a free-running microsecond tick. Next it reads the upper identifier byte from offset 0. It reads the lower byte from an offset chosen by the upper byte. Last, it reopens the gate and writes the command that returns the device to array-read mode.

The two bytes form a 16-bit identifier. A decoder turns it into a verdict: a supported large part, a supported small part, or unsupported. The size-select bit tells later logic whether the flash window spans 4 MiB or 1 MiB. A one-cycle done pulse marks the point where the identifier and verdict outputs take their new values. Those outputs then keep their values until the next probe completes.

The controller is a single state machine with these states:
- IDLE waits for start.
- GATE_ID raises the gate request until the gate reports open.
- WR_ID issues the identify write.
- WAIT counts ticks.
- RD_HI issues the first read and CAP_HI captures its data.
- RD_LO issues the second read and CAP_LO captures its data.
- GATE_RST raises the gate request again.
- WR_RST issues the array-read write.

The transitions are:
- IDLE→GATE_ID on start.
- GATE_ID→WR_ID and GATE_RST→WR_RST when the gate reports open.
- WR_ID→WAIT always.
- WAIT→RD_HI when the tick count is reached.
- RD_HI→CAP_HI→RD_LO→CAP_LO→GATE_RST unconditionally.
- WR_RST→IDLE, which also loads the results and pulses done.

Top module: `flash_id_probe`

## Requirements
- R1: After an accepted start, `gate_req_o` is raised. The identify write (data 0x90 at offset 0x8000) is issued only in a cycle in which `gate_open_i` is high and that follows a cycle in which the request was high and the gate was open.
- R2: The first read, at offset 0, is issued only after at least WAIT_US+1 tick pulses have been seen in the cycles following the identify write. This guarantees at least WAIT_US whole microseconds of settling.
- R3: If the first byte read equals 0xB0, the second read uses offset 2. Otherwise it uses offset 1.
- R4: `id_o` carries the first byte in bits 15:8 and the second byte in bits 7:0.
- R5: After both reads, the block writes 0xFF to offset 0x8000 under the same gate handshake as R1. This leaves the device in array-read mode before done.
- R6: Identifier 0xB0D4 gives `id_ok_o`=1 and `size_big_o`=1 (4 MiB). Identifier 0x89A6 gives `id_ok_o`=1 and `size_big_o`=0 (1 MiB). Any other identifier gives `id_ok_o`=0 and `size_big_o`=0.
- R7: `done_o` is high for exactly one cycle, the cycle after the array-read write. `id_o`, `id_ok_o` and `size_big_o` change only in a cycle where `done_o` is high.
- R8: A start pulse that arrives while a probe is in progress has no effect. Each accepted start yields exactly one identify write and one done pulse.
- R9: While reset is asserted, every output is zero. Write and read strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse; ignored while busy |
| tick_us_i | input | 1 | One-cycle pulse once per microsecond |
| gate_open_i | input | 1 | External write gate reports open |
| bus_rdata_i | input | 8 | Read data, valid the cycle after the read strobe |
| gate_req_o | output | 1 | Request to open the write gate |
| bus_addr_o | output | ADDR_W | Byte offset into the flash window |
| bus_wdata_o | output | 8 | Command byte for writes |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| id_o | output | 16 | Identifier from the last completed probe |
| id_ok_o | output | 1 | Identifier is a supported part |
| size_big_o | output | 1 | 1: 4 MiB device, 0: 1 MiB or unsupported |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of events can share a cycle. A fresh start pulse can land while the previous probe is still running. The new results can become visible in the same cycle that the old ones were being held. The bench provokes the first by pulsing start again during the tick wait and during the reads. It judges the outcome by counting identify writes and done pulses against accepted starts. It also watches `id_o` on every cycle, so any change outside a done cycle is reported. Offset selection is judged with a device model that returns different bytes at offsets 1 and 2, so a wrong choice shows up as a wrong identifier.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GATE_ID,
        ST_WR_ID,
        ST_WAIT,
        ST_RD_HI,
        ST_CAP_HI,
        ST_RD_LO,
        ST_CAP_LO,
        ST_GATE_RST,
        ST_WR_RST
    } probe_state_t;

    localparam logic [7:0]  CMD_IDENTIFY = 8'h90;
    localparam logic [7:0]  CMD_ARRAY    = 8'hFF;
    localparam logic [7:0]  HI_WIDE_MARK = 8'hB0;
    localparam logic [15:0] ID_PART_BIG  = 16'hB0D4;
    localparam logic [15:0] ID_PART_SML  = 16'h89A6;

endpackage

// File: rtl/flash_probe_timer.sv
module flash_probe_timer #(
    parameter int unsigned TICKS = 16,
    localparam int unsigned CW   = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam logic [CW-1:0] LIMIT = CW'(TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/flash_probe_decode.sv
module flash_probe_decode
    import flash_probe_pkg::*;
(
    input  logic [15:0] id_i,
    output logic        known_o,
    output logic        big_o
);
    always_comb begin
        known_o = 1'b0;
        big_o   = 1'b0;
        if (id_i == ID_PART_BIG) begin
            known_o = 1'b1;
            big_o   = 1'b1;
        end else if (id_i == ID_PART_SML) begin
            known_o = 1'b1;
        end
    end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
    import flash_probe_pkg::*;
#(
    parameter int unsigned ADDR_W  = 22,
    parameter int unsigned WAIT_US = 15,
    parameter int unsigned CMD_OFS = 32'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_us_i,
    input  logic              gate_open_i,
    input  logic [7:0]        bus_rdata_i,
    output logic              gate_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    output logic              bus_wr_o,
    output logic              bus_rd_o,
    output logic [15:0]       id_o,
    output logic              id_ok_o,
    output logic              size_big_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] OFS_HI   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_LO_N = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_LO_W = ADDR_W'(2);

    probe_state_t state_q, state_d;
    logic [7:0]   hi_q, lo_q;
    logic         wait_done;
    logic         dec_known, dec_big;

    // settle timer: one extra tick covers a partial first microsecond
    flash_probe_timer #(.TICKS(WAIT_US + 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (state_q == ST_WR_ID),
        .tick_i   (tick_us_i),
        .expired_o(wait_done)
    );

    flash_probe_decode u_decode (
        .id_i   ({hi_q, lo_q}),
        .known_o(dec_known),
        .big_o  (dec_big)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i)     state_d = ST_GATE_ID;
            ST_GATE_ID:  if (gate_open_i) state_d = ST_WR_ID;
            ST_WR_ID:                     state_d = ST_WAIT;
            ST_WAIT:     if (wait_done)   state_d = ST_RD_HI;
            ST_RD_HI:                     state_d = ST_CAP_HI;
            ST_CAP_HI:                    state_d = ST_RD_LO;
            ST_RD_LO:                     state_d = ST_CAP_LO;
            ST_CAP_LO:                    state_d = ST_GATE_RST;
            ST_GATE_RST: if (gate_open_i) state_d = ST_WR_RST;
            ST_WR_RST:                    state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        gate_req_o  = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = 8'h00;
        bus_wr_o    = 1'b0;
        bus_rd_o    = 1'b0;
        unique case (state_q)
            ST_GATE_ID, ST_GATE_RST: gate_req_o = 1'b1;
            ST_WR_ID: begin
                bus_wr_o    = 1'b1;
                bus_addr_o  = CMD_ADDR;
                bus_wdata_o = CMD_IDENTIFY;
            end
            ST_RD_HI: begin
                bus_rd_o   = 1'b1;
                bus_addr_o = OFS_HI;
            end
            ST_RD_LO: begin
                bus_rd_o   = 1'b1;
                bus_addr_o = (hi_q == HI_WIDE_MARK) ? OFS_LO_W : OFS_LO_N;
            end
            ST_WR_RST: begin
                bus_wr_o    = 1'b1;
                bus_addr_o  = CMD_ADDR;
                bus_wdata_o = CMD_ARRAY;
            end
            default: ;
        endcase
    end

    // byte capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= 8'h00;
            lo_q <= 8'h00;
        end else begin
            if (state_q == ST_CAP_HI) hi_q <= bus_rdata_i;
            if (state_q == ST_CAP_LO) lo_q <= bus_rdata_i;
        end
    end

    // result registers and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_o       <= 16'h0000;
            id_ok_o    <= 1'b0;
            size_big_o <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            done_o <= (state_q == ST_WR_RST);
            if (state_q == ST_WR_RST) begin
                id_o       <= {hi_q, lo_q};
                id_ok_o    <= dec_known;
                size_big_o <= dec_big;
            end
        end
    end
endmodule

// File: rtl/flash_probe_checker.sv
module flash_probe_checker #(
    parameter int unsigned ADDR_W  = 22,
    parameter int unsigned WAIT_US = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_us_i,
    input logic              gate_open_i,
    input logic [7:0]        bus_rdata_i,
    input logic              gate_req_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [7:0]        bus_wdata_o,
    input logic              bus_wr_o,
    input logic              bus_rd_o,
    input logic [15:0]       id_o,
    input logic              id_ok_o,
    input logic              size_big_o,
    input logic              done_o
);
    logic [15:0] ticks_since_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_since_cmd <= '0;
        end else if (bus_wr_o && bus_wdata_o == 8'h90) begin
            ticks_since_cmd <= '0;
        end else if (tick_us_i && ticks_since_cmd != 16'hFFFF) begin
            ticks_since_cmd <= ticks_since_cmd + 1'b1;
        end
    end

    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_o |-> (gate_open_i && $past(gate_req_o && gate_open_i))); // R1
    AST_SETTLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o && bus_addr_o == '0) |-> (ticks_since_cmd >= 16'(WAIT_US + 1))); // R2
    AST_LO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o && $past(bus_rd_o, 2)) |->
        (bus_addr_o == (($past(bus_rdata_i) == 8'hB0) ? ADDR_W'(2) : ADDR_W'(1)))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bus_wr_o && bus_wdata_o == 8'hFF)); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({id_o, id_ok_o, size_big_o}) |-> done_o); // R7
    AST_BIG_IS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        size_big_o |-> id_ok_o); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_wr_o, bus_rd_o})); // R9
endmodule

bind flash_id_probe flash_probe_checker #(.ADDR_W(ADDR_W), .WAIT_US(WAIT_US)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_us_i  (tick_us_i),
    .gate_open_i(gate_open_i),
    .bus_rdata_i(bus_rdata_i),
    .gate_req_o (gate_req_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_wr_o   (bus_wr_o),
    .bus_rd_o   (bus_rd_o),
    .id_o       (id_o),
    .id_ok_o    (id_ok_o),
    .size_big_o (size_big_o),
    .done_o     (done_o)
);

// File: tb/tb_flash_id_probe.sv
module tb_flash_id_probe;
    localparam int ADDR_W  = 22;
    localparam int WAIT_US = 15;

    typedef struct packed {
        logic [15:0] id;
        logic        ok;
        logic        big;
        logic [1:0]  addr2;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic tick_us_i = 1'b0;
    logic gate_open_i;
    logic [7:0] bus_rdata_i = 8'h00;
    logic gate_req_o;
    logic [ADDR_W-1:0] bus_addr_o;
    logic [7:0] bus_wdata_o;
    logic bus_wr_o, bus_rd_o;
    logic [15:0] id_o;
    logic id_ok_o, size_big_o, done_o;

    always #5 clk = ~clk;

    flash_id_probe #(.ADDR_W(ADDR_W), .WAIT_US(WAIT_US)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_us_i(tick_us_i),
        .gate_open_i(gate_open_i), .bus_rdata_i(bus_rdata_i),
        .gate_req_o(gate_req_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .id_o(id_o), .id_ok_o(id_ok_o),
        .size_big_o(size_big_o), .done_o(done_o)
    );

    int checks = 0;
    int failures = 0;
    exp_t sb[$];

    // device and gate models
    logic [7:0] dev_hi = 8'h00, dev_lo1 = 8'h00, dev_lo2 = 8'h00;
    logic       dev_id_mode = 1'b0;
    logic [2:0] gate_pipe = 3'b000;
    assign gate_open_i = gate_pipe[2];

    always @(posedge clk) begin
        gate_pipe <= {gate_pipe[1:0], gate_req_o};
        if (bus_wr_o && bus_addr_o == ADDR_W'(32'h8000)) begin
            if (bus_wdata_o == 8'h90) dev_id_mode <= 1'b1;
            if (bus_wdata_o == 8'hFF) dev_id_mode <= 1'b0;
        end
        if (bus_rd_o) begin
            if (!dev_id_mode)                   bus_rdata_i <= 8'hEE;
            else if (bus_addr_o == ADDR_W'(0))  bus_rdata_i <= dev_hi;
            else if (bus_addr_o == ADDR_W'(1))  bus_rdata_i <= dev_lo1;
            else if (bus_addr_o == ADDR_W'(2))  bus_rdata_i <= dev_lo2;
            else                                bus_rdata_i <= 8'h00;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // monitor: bus rules, tick generation, scoreboard compare
    int cyc = 0, ident_wr = 0, done_cnt = 0, rd_idx = 0, tick_seen = 0, div = 0;
    logic [ADDR_W-1:0] addr2_seen = '0;
    logic prev_req = 1'b0, prev_open = 1'b0, prev_done = 1'b0;
    logic [15:0] last_id = 16'h0;
    exp_t e;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(1'b0, "WATCHDOG", "run hung", 32'(cyc), 32'd100000);
            finish_run();
        end
        if (rst_n) begin
            if (bus_wr_o && bus_rd_o) check(1'b0, "R9", "both strobes", 32'd1, 32'd0);
            if (bus_wr_o) begin
                check(gate_open_i && prev_req && prev_open,
                      bus_wdata_o == 8'h90 ? "R1" : "R5", "write without open gate",
                      {prev_req, prev_open, gate_open_i}, 32'd7);
                check(bus_addr_o == ADDR_W'(32'h8000), "R1", "command offset",
                      32'(bus_addr_o), 32'h8000);
                if (bus_wdata_o == 8'h90) begin
                    ident_wr++;
                    rd_idx = 0;
                end else begin
                    check(bus_wdata_o == 8'hFF && rd_idx == 2, "R5",
                          "restore write data/order", {bus_wdata_o, 8'(rd_idx)}, 32'hFF02);
                end
            end
            if (bus_rd_o) begin
                rd_idx++;
                if (rd_idx == 1) begin
                    check(bus_addr_o == '0, "R2", "first read offset", 32'(bus_addr_o), 0);
                    check(tick_seen >= WAIT_US + 1, "R2", "ticks before first read",
                          32'(tick_seen), 32'(WAIT_US + 1));
                end else if (rd_idx == 2) begin
                    addr2_seen = bus_addr_o;
                end
            end
            if (done_o) begin
                done_cnt++;
                check(!prev_done, "R7", "done wider than one cycle", 32'd1, 32'd0);
                if (sb.size() == 0) begin
                    check(1'b0, "R8", "unexpected done", 32'd1, 32'd0);
                end else begin
                    e = sb.pop_front();
                    check(id_o == e.id, "R4", "identifier", 32'(id_o), 32'(e.id));
                    check(id_ok_o == e.ok, "R6", "supported verdict", 32'(id_ok_o), 32'(e.ok));
                    check(size_big_o == e.big, "R6", "size select", 32'(size_big_o), 32'(e.big));
                    check(addr2_seen == ADDR_W'(e.addr2), "R3", "second read offset",
                          32'(addr2_seen), 32'(e.addr2));
                    check(!dev_id_mode, "R5", "device left in identify mode",
                          32'(dev_id_mode), 32'd0);
                end
            end else if (id_o != last_id) begin
                check(1'b0, "R7", "id changed without done", 32'(id_o), 32'(last_id));
            end
            if (bus_wr_o && bus_wdata_o == 8'h90) tick_seen = 0;
            else if (tick_us_i) tick_seen++;
        end
        last_id   = id_o;
        prev_req  = gate_req_o;
        prev_open = gate_open_i;
        prev_done = done_o;
        div       = (div == 3) ? 0 : div + 1;
        tick_us_i = (div == 3);
    end

    // driver: pushes expectation, launches a probe, optionally pokes start while busy
    int launched = 0;
    task automatic probe(input logic [7:0] hi, input logic [7:0] lo1,
                         input logic [7:0] lo2, input bit poke);
        exp_t x;
        int prior;
        x.id    = {hi, (hi == 8'hB0) ? lo2 : lo1};
        x.ok    = (x.id == 16'hB0D4) || (x.id == 16'h89A6);
        x.big   = (x.id == 16'hB0D4);
        x.addr2 = (hi == 8'hB0) ? 2'd2 : 2'd1;
        dev_hi = hi; dev_lo1 = lo1; dev_lo2 = lo2;
        sb.push_back(x);
        prior = done_cnt;
        launched++;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        if (poke) begin // R8: starts during wait and during reads are ignored
            repeat (20) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
            while (!bus_rd_o) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end
        while (done_cnt == prior) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check({gate_req_o, bus_wr_o, bus_rd_o, done_o, id_ok_o, size_big_o} == 6'b0,
              "R9", "control outputs in reset",
              32'({gate_req_o, bus_wr_o, bus_rd_o, done_o, id_ok_o, size_big_o}), 0);
        check(id_o == 16'h0, "R9", "id in reset", 32'(id_o), 0);
        check(bus_addr_o == '0 && bus_wdata_o == 8'h0, "R9", "bus in reset",
              32'(bus_addr_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!gate_req_o, "R1", "no request without start", 32'(gate_req_o), 0);

        probe(8'hB0, 8'h11, 8'hD4, 1'b0);   // large part
        probe(8'h89, 8'hA6, 8'hD4, 1'b1);   // small part, busy starts
        probe(8'hB0, 8'hD4, 8'h00, 1'b0);   // wide mark: offset 1 must be skipped
        probe(8'h89, 8'hA7, 8'hA6, 1'b1);   // near miss, unsupported
        probe(8'h12, 8'h34, 8'hD4, 1'b0);   // unknown vendor
        probe(8'hB0, 8'hD4, 8'hD5, 1'b0);   // near miss on large part
        probe(8'h89, 8'hA6, 8'h00, 1'b0);   // small again after unsupported

        repeat (40) @(negedge clk);
        check(ident_wr == launched, "R8", "identify writes per accepted start",
              32'(ident_wr), 32'(launched));
        check(done_cnt == launched, "R8", "done pulses per accepted start",
              32'(done_cnt), 32'(launched));
        check(sb.size() == 0, "R7", "results left unreported", 32'(sb.size()), 0);
        finish_run();
    end
endmodule